// File: doc/BRIEF.md
# Paged Address Translation Unit

This block widens a 16-bit CPU address into a 20-bit physical memory address. The top four logical address bits pick one of sixteen slots in a small writable mapping table, and that slot's 8-bit entry becomes the upper part of the physical address. The low twelve bits carry through untouched, so memory is managed in 4 KB pages and any of the 256 physical pages can appear in any logical slot.

The lookup is purely combinational from the table registers. Software loads the table through a 16-entry register window: the window offset names the slot and the written byte is the page number. Reading the same window returns the stored entry, so boot code can verify the map. After reset the table holds an identity map of the lowest 64 KB, which lets code run before the map is programmed.

Top module: `page_xlate`

## Requirements
- R1: While reset is asserted and after it is released with no writes, slot n holds page n for every slot 0 to 15 (identity map of the low 64 KB).
- R2: phys_addr[11:0] always equals log_addr[11:0] in the same cycle.
- R3: phys_addr[19:12] equals the entry of slot log_addr[15:12], combinationally in the same cycle.
- R4: When map_sel and map_wr are both high at a rising clock edge, map_wdata is stored into slot map_idx and is used by lookups from the following cycle.
- R5: A clock edge with map_sel low or map_wr low changes no entry.
- R6: A write changes only its own slot; several slots may hold the same page and each translates to it.
- R7: With map_sel high, map_rdata shows the entry of slot map_idx in the same cycle; with map_sel low, map_rdata is 0.
- R8: In a cycle where a write targets the slot that log_addr selects, phys_addr still shows the old entry until the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| log_addr | input | 16 | Logical CPU address |
| phys_addr | output | 20 | Translated physical address |
| map_sel | input | 1 | Mapping register window selected |
| map_wr | input | 1 | Write strobe for the window |
| map_idx | input | 4 | Slot index (window offset) |
| map_wdata | input | 8 | Page number to store |
| map_rdata | output | 8 | Stored page number of the selected slot |

## Verification
Lookups are tried with random addresses against the reset identity map, then against a map scrambled by random writes, which separates a correct slot index from a stuck or miswired one and shows the offset passes through for any page. Writes with only one of map_sel and map_wr high are mixed in, so an entry that changes on a half-qualified strobe stands out in later lookups and readbacks. Directed cases load one page into two slots, and look up a slot in the very cycle it is written, which tells a table read before the edge from one that forwards the new data.

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int LOG_AW    = 16,
  parameter int SLOT_BITS = 4,
  parameter int PAGE_BITS = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [LOG_AW-1:0]                      log_addr,
  output logic [LOG_AW-SLOT_BITS+PAGE_BITS-1:0]  phys_addr,
  input  logic                                   map_sel,
  input  logic                                   map_wr,
  input  logic [SLOT_BITS-1:0]                   map_idx,
  input  logic [PAGE_BITS-1:0]                   map_wdata,
  output logic [PAGE_BITS-1:0]                   map_rdata
);
  localparam int OFS_BITS = LOG_AW - SLOT_BITS;
  localparam int SLOTS    = 1 << SLOT_BITS;

  typedef logic [SLOTS-1:0][PAGE_BITS-1:0] tab_t;

  function automatic tab_t ident_map();
    tab_t t;
    for (int i = 0; i < SLOTS; i++) t[i] = PAGE_BITS'(i);
    return t;
  endfunction

  tab_t tab;
  logic wr_en;
  logic [SLOT_BITS-1:0] slot;

  assign wr_en = map_sel & map_wr;
  assign slot  = log_addr[LOG_AW-1:OFS_BITS];

  always_ff @(posedge clk) begin
    if (!rst_n)     tab <= ident_map();
    else if (wr_en) tab[map_idx] <= map_wdata;
  end

  assign phys_addr = {tab[slot], log_addr[OFS_BITS-1:0]};
  assign map_rdata = map_sel ? tab[map_idx] : '0;

  // checks
  AST_RESET_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (tab == ident_map())); // R1

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (tab[$past(map_idx)] == $past(map_wdata))); // R4

  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(tab)); // R5

  AST_PHYS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(log_addr) && !$past(wr_en)) |-> $stable(phys_addr)); // R3

  AST_OFS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(log_addr) |-> $stable(phys_addr[OFS_BITS-1:0])); // R2
endmodule

// File: tb/page_xlate_test.sv
module page_xlate_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] log_addr = '0;
  logic [19:0] phys_addr;
  logic        map_sel = 1'b0;
  logic        map_wr = 1'b0;
  logic [3:0]  map_idx = '0;
  logic [7:0]  map_wdata = '0;
  logic [7:0]  map_rdata;

  int checks = 0;
  int failures = 0;
  logic [7:0] model [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  page_xlate uut (
    .clk(clk), .rst_n(rst_n), .log_addr(log_addr), .phys_addr(phys_addr),
    .map_sel(map_sel), .map_wr(map_wr), .map_idx(map_idx),
    .map_wdata(map_wdata), .map_rdata(map_rdata)
  );

  function automatic logic [19:0] exp_phys(logic [15:0] a);
    return {model[a[15:12]], a[11:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lookup(logic [15:0] a, string req);
    @(negedge clk);
    map_sel = 1'b0; map_wr = 1'b0;
    log_addr = a;
    #1;
    chk(req, 32'(phys_addr), 32'(exp_phys(a)));
    chk({req, " R2"}, 32'(phys_addr[11:0]), 32'(a[11:0]));
  endtask

  task automatic readback(logic [3:0] idx, string req);
    @(negedge clk);
    map_sel = 1'b1; map_wr = 1'b0; map_idx = idx;
    #1;
    chk(req, 32'(map_rdata), 32'(model[idx]));
  endtask

  task automatic wr(logic sel, logic we, logic [3:0] idx, logic [7:0] d);
    logic [15:0] a;
    @(negedge clk);
    a = {idx, 12'($urandom)};
    map_sel = sel; map_wr = we; map_idx = idx; map_wdata = d; log_addr = a;
    #1;
    chk("R8 old entry during write", 32'(phys_addr), 32'(exp_phys(a)));
    @(posedge clk);
    if (sel && we) model[idx] = d;
    @(negedge clk);
    map_sel = 1'b0; map_wr = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) model[i] = 8'(i);
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset identity", 32'(phys_addr), 32'(exp_phys(log_addr)));
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) readback(4'(i), "R1 identity readback");
    lookup(16'hF123, "R3 identity lookup top slot");
    @(negedge clk);
    map_sel = 1'b0; map_idx = 4'd5;
    #1;
    chk("R7 deselected reads zero", 32'(map_rdata), 32'd0);

    wr(1'b1, 1'b1, 4'd3, 8'hA7);
    lookup(16'h3ABC, "R4 new page visible");
    wr(1'b1, 1'b1, 4'd9, 8'hA7);
    lookup(16'h9001, "R6 shared page slot 9");
    lookup(16'h3FFF, "R6 shared page slot 3");
    readback(4'd4, "R6 neighbour untouched");
    wr(1'b0, 1'b1, 4'd3, 8'h11);
    readback(4'd3, "R5 unselected write ignored");
    wr(1'b1, 1'b0, 4'd3, 8'h22);
    lookup(16'h3000, "R5 no strobe write ignored");
    wr(1'b1, 1'b1, 4'd0, 8'hFF);
    lookup(16'h0FFF, "R4 max page boundary");
    wr(1'b1, 1'b1, 4'd15, 8'h00);
    lookup(16'hFFFF, "R4 top slot to page 0");

    for (int n = 0; n < 300; n++) begin
      case ($urandom % 3)
        0: wr(1'($urandom), 1'($urandom), 4'($urandom), 8'($urandom));
        1: lookup(16'($urandom), "R3 random lookup");
        default: readback(4'($urandom), "R7 random readback");
      endcase
    end
    for (int i = 0; i < 16; i++) readback(4'(i), "R7 final readback");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule